// File: doc/BRIEF.md
# Multi-Panel Flash Write Buffer Controller

This block sits on the device side of a nonvolatile program memory that is split into equal panels. Program data arrives as byte or halfword writes addressed by a 22-bit table pointer. The block splits the pointer into a panel number, a row offset inside the panel and a byte position inside an 8-byte row buffer, and places each write into that panel's own staging buffer. A later commit request moves the staged rows into the array in one programming event.

A mode register picks between two commit styles. In multi-panel mode, every panel is programmed at once, all at the same row offset. In single-panel mode, only the panel named by the commit pointer is programmed. The commit pointer's row offset must match the offset that was used while the buffers were loaded. If it does not, the commit is refused and an error is raised. An accepted commit raises a program strobe toward the array. The strobe stays high for as long as an external timing input is held high. When it drops, every buffer returns to the erased value of all ones and forgets that it was loaded. The 64-byte erase region of the write pointer is also decoded and presented. No erase is carried out.

Top module: `mpw_flash_wbuf`

## Requirements
- R1: Out of reset, `prog_strobe`, `cmt_err` and `multi_mode` are 0 and every byte of `prog_data` is FFh.
- R2: A byte write (`wr_half`=0) to a valid panel stores `wr_data[7:0]` at byte `wr_ptr[2:0]` of panel `wr_ptr[21:13]`. It is visible on `prog_data[(panel*8+byte)*8 +: 8]` one cycle later.
- R3: A halfword write (`wr_half`=1) stores `wr_data[7:0]` at the even byte `{wr_ptr[2:1],0}` and `wr_data[15:8]` at the odd byte `{wr_ptr[2:1],1}` of the addressed panel.
- R4: A write whose panel field is `NUM_PANELS` or above leaves every buffer unchanged. A write made while `prog_strobe` is high also leaves every buffer unchanged.
- R5: A configuration write of value 40h to address 3C0006h sets `multi_mode`. Any other value written to that address clears it. Writes to other addresses, and any configuration write while `prog_strobe` is high, leave it unchanged.
- R6: In multi-panel mode, an accepted commit drives `prog_mask` to all ones and `prog_row` to `commit_ptr[12:3]`.
- R7: In single-panel mode, an accepted commit drives `prog_mask` one-hot on panel `commit_ptr[21:13]`. `prog_row` is driven as in R6.
- R8: `prog_strobe` rises in the cycle after an accepted commit request. It stays high while `prog_hold` is 1 and falls in the cycle after `prog_hold` is seen at 0.
- R9: When any buffer is loaded and `commit_ptr[12:3]` differs from the row offset of the last accepted write, the commit is refused. In that case `cmt_err` goes to 1, no strobe is raised and the buffers are kept. `cmt_err` returns to 0 on the next accepted commit.
- R10: When the strobe falls, every buffer byte becomes FFh and every loaded flag clears. A later commit at any row offset is then accepted without error.
- R11: `erase_blk` always equals `wr_ptr[12:6]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Data write strobe |
| wr_half | input | 1 | 1 = halfword write, 0 = byte write |
| wr_ptr | input | 22 | Table pointer for the data write |
| wr_data | input | 16 | Write data; only the low byte is used for byte writes |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 22 | Configuration write address |
| cfg_data | input | 8 | Configuration write value |
| commit_req | input | 1 | Request a programming event |
| commit_ptr | input | 19 | Commit pointer bits [21:3]: panel and row offset |
| prog_hold | input | 1 | External programming-time hold; the strobe lasts while it is 1 |
| multi_mode | output | 1 | 1 = multi-panel mode |
| prog_strobe | output | 1 | Program strobe toward the array |
| prog_mask | output | NUM_PANELS | Panels to program during the strobe |
| prog_row | output | 10 | Row offset to program |
| prog_data | output | NUM_PANELS*64 | Buffer contents; panel p byte b at bits (p*8+b)*8 |
| cmt_err | output | 1 | Last commit refused for offset mismatch |
| erase_blk | output | 7 | Erase-region decode of wr_ptr |

## Verification
The first stimulus is a byte-by-byte sweep over every byte slot of every panel, followed by two panel numbers that do not exist. Because each slot gets a different value, a swapped panel field or byte field shows up at once, and writes to the nonexistent panels show whether out-of-range panels are really dropped. A halfword sweep over all eight byte positions, odd ones included, separates correct even/odd placement from simple byte indexing. Commits are then issued in both modes at matching and mismatching row offsets, and writes are attempted while the strobe is high. These cases separate mask generation, the offset check, strobe timing and the clear to all ones. An erase-region sweep walks all 128 values of pointer bits [12:6].

// File: rtl/mpw_pkg.sv
// Shared constants and pointer-field type for the multi-panel write controller.
// Assumes the 22-bit pointer layout panel[21:13], row[12:3], byte[2:0].
package mpw_pkg;
    localparam int PTR_W     = 22;
    localparam int IDX_W     = 3;
    localparam int BUF_BYTES = 1 << IDX_W;
    localparam int ROW_W     = 10;
    localparam int PNL_W     = PTR_W - ROW_W - IDX_W;
    localparam int ERS_W     = 7;
    localparam int ERS_LSB   = PTR_W - PNL_W - ERS_W;

    typedef struct packed {
        logic [PNL_W-1:0] pnl;
        logic [ROW_W-1:0] row;
        logic [IDX_W-1:0] idx;
        logic [ERS_W-1:0] ers;
    } ptr_fields_t;
endpackage

// File: rtl/mpw_ptr_decode.sv
// Splits a table pointer into panel, row offset, byte index and erase region.
// Purely combinational; assumes the field layout from mpw_pkg.
module mpw_ptr_decode
    import mpw_pkg::*;
(
    input  logic [PTR_W-1:0] ptr,
    output ptr_fields_t      fields
);
    // Field extraction.
    always_comb begin
        fields.idx = ptr[IDX_W-1:0];
        fields.row = ptr[IDX_W +: ROW_W];
        fields.pnl = ptr[PTR_W-1 -: PNL_W];
        fields.ers = ptr[ERS_LSB +: ERS_W];
    end
endmodule

// File: rtl/mpw_panel_buf.sv
// One panel's row staging buffer: byte or halfword writes, loaded flag, and a
// clear that restores the erased value. Assumes the caller has already gated
// we with panel selection and the busy state.
module mpw_panel_buf
    import mpw_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   we,
    input  logic                   half,
    input  logic [IDX_W-1:0]       idx,
    input  logic [15:0]            din,
    input  logic                   clr,
    output logic [BUF_BYTES*8-1:0] q,
    output logic                   loaded
);
    logic [7:0] mem [BUF_BYTES];

    // Storage update: reset/clear to erased state, otherwise byte or halfword write.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            for (int b = 0; b < BUF_BYTES; b++) mem[b] <= 8'hFF;
            loaded <= 1'b0;
        end else if (we) begin
            if (half) begin
                mem[{idx[IDX_W-1:1], 1'b0}] <= din[7:0];
                mem[{idx[IDX_W-1:1], 1'b1}] <= din[15:8];
            end else begin
                mem[idx] <= din[7:0];
            end
            loaded <= 1'b1;
        end
    end

    // Flatten the storage to the output bus, byte 0 in the low bits.
    always_comb begin
        for (int b = 0; b < BUF_BYTES; b++) q[b*8 +: 8] = mem[b];
    end
endmodule

// File: rtl/mpw_commit_ctl.sv
// Commit sequencer: checks the row offset against the load offset, builds the
// panel mask, holds the strobe while the external hold is high, then clears.
// Assumes commit requests arrive as single-cycle pulses while idle.
module mpw_commit_ctl
    import mpw_pkg::*;
#(
    parameter int NUM_PANELS = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  commit_req,
    input  logic [PNL_W-1:0]      cmt_pnl,
    input  logic [ROW_W-1:0]      cmt_row,
    input  logic                  multi,
    input  logic                  any_loaded,
    input  logic                  wr_ok,
    input  logic [ROW_W-1:0]      wr_row,
    input  logic                  prog_hold,
    output logic                  prog_strobe,
    output logic [NUM_PANELS-1:0] prog_mask,
    output logic [ROW_W-1:0]      prog_row,
    output logic                  cmt_err,
    output logic                  buf_clr
);
    typedef enum logic {CC_IDLE, CC_PROG} cc_state_t;
    cc_state_t state;
    logic [ROW_W-1:0]      load_row;
    logic                  mismatch, accept;
    logic [NUM_PANELS-1:0] mask_d;

    // Commit qualification and mask selection.
    always_comb begin
        mismatch = any_loaded && (cmt_row != load_row);
        accept   = commit_req && (state == CC_IDLE) && !mismatch;
        for (int p = 0; p < NUM_PANELS; p++)
            mask_d[p] = multi || (cmt_pnl == PNL_W'(p));
        buf_clr  = (state == CC_PROG) && !prog_hold;
    end

    // Remember the row offset of the last accepted write.
    always_ff @(posedge clk) begin
        if (!rst_n)     load_row <= '0;
        else if (wr_ok) load_row <= wr_row;
    end

    // Sequencer state, latched mask/row and error flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= CC_IDLE;
            prog_mask <= '0;
            prog_row  <= '0;
            cmt_err   <= 1'b0;
        end else if (state == CC_IDLE) begin
            if (accept) begin
                state     <= CC_PROG;
                prog_mask <= mask_d;
                prog_row  <= cmt_row;
                cmt_err   <= 1'b0;
            end else if (commit_req) begin
                cmt_err   <= 1'b1;
            end
        end else if (!prog_hold) begin
            state     <= CC_IDLE;
            prog_mask <= '0;
        end
    end

    assign prog_strobe = (state == CC_PROG);
endmodule

// File: rtl/mpw_flash_wbuf.sv
// Top of the multi-panel write buffer controller: decodes the write pointer,
// steers writes into per-panel buffers, holds the mode register and hands
// commits to the sequencer. Assumes a single clock with synchronous reset.
module mpw_flash_wbuf
    import mpw_pkg::*;
#(
    parameter int              NUM_PANELS    = 4,
    parameter logic [PTR_W-1:0] MODE_REG_ADDR = 22'h3C0006,
    parameter logic [7:0]       MULTI_KEY     = 8'h40
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            wr_en,
    input  logic                            wr_half,
    input  logic [PTR_W-1:0]                wr_ptr,
    input  logic [15:0]                     wr_data,
    input  logic                            cfg_we,
    input  logic [PTR_W-1:0]                cfg_addr,
    input  logic [7:0]                      cfg_data,
    input  logic                            commit_req,
    input  logic [PTR_W-1:IDX_W]            commit_ptr,
    input  logic                            prog_hold,
    output logic                            multi_mode,
    output logic                            prog_strobe,
    output logic [NUM_PANELS-1:0]           prog_mask,
    output logic [ROW_W-1:0]                prog_row,
    output logic [NUM_PANELS*BUF_BYTES*8-1:0] prog_data,
    output logic                            cmt_err,
    output logic [ERS_W-1:0]                erase_blk
);
    localparam int PBITS = BUF_BYTES * 8;

    ptr_fields_t           wf;
    logic                  wr_ok, buf_clr;
    logic [NUM_PANELS-1:0] loaded;

    mpw_ptr_decode dec_i (.ptr(wr_ptr), .fields(wf));

    // Accept data writes only for existing panels and only while not programming.
    assign wr_ok     = wr_en && !prog_strobe && (wf.pnl < PNL_W'(NUM_PANELS));
    assign erase_blk = wf.ers;

    // One staging buffer per panel.
    for (genvar p = 0; p < NUM_PANELS; p++) begin : g_panel
        mpw_panel_buf buf_i (
            .clk    (clk),
            .rst_n  (rst_n),
            .we     (wr_ok && (wf.pnl == PNL_W'(p))),
            .half   (wr_half),
            .idx    (wf.idx),
            .din    (wr_data),
            .clr    (buf_clr),
            .q      (prog_data[p*PBITS +: PBITS]),
            .loaded (loaded[p])
        );
    end

    // Mode register: the key value selects multi-panel mode, anything else single.
    always_ff @(posedge clk) begin
        if (!rst_n)
            multi_mode <= 1'b0;
        else if (cfg_we && !prog_strobe && (cfg_addr == MODE_REG_ADDR))
            multi_mode <= (cfg_data == MULTI_KEY);
    end

    mpw_commit_ctl #(.NUM_PANELS(NUM_PANELS)) ctl_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .commit_req  (commit_req),
        .cmt_pnl     (commit_ptr[PTR_W-1 -: PNL_W]),
        .cmt_row     (commit_ptr[IDX_W +: ROW_W]),
        .multi       (multi_mode),
        .any_loaded  (|loaded),
        .wr_ok       (wr_ok),
        .wr_row      (wf.row),
        .prog_hold   (prog_hold),
        .prog_strobe (prog_strobe),
        .prog_mask   (prog_mask),
        .prog_row    (prog_row),
        .cmt_err     (cmt_err),
        .buf_clr     (buf_clr)
    );
endmodule

// File: rtl/mpw_flash_wbuf_chk.sv
// Property checker for mpw_flash_wbuf, attached by bind below.
// Observes top-level ports only.
module mpw_flash_wbuf_chk #(
    parameter int NUM_PANELS = 4
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       commit_req,
    input logic                       multi_mode,
    input logic                       prog_strobe,
    input logic [NUM_PANELS-1:0]      prog_mask,
    input logic [NUM_PANELS*64-1:0]   prog_data,
    input logic                       cmt_err
);
    // R7
    single_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_strobe && !multi_mode) |-> $onehot0(prog_mask));
    // R6
    multi_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_strobe && multi_mode) |-> (&prog_mask));
    // R4
    hold_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        prog_strobe |=> (!prog_strobe || $stable(prog_data)));
    // R10
    clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(prog_strobe) |-> (&prog_data));
    // R8
    start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(prog_strobe) |-> $past(commit_req));
    // R9
    err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmt_err |-> !prog_strobe);
endmodule

bind mpw_flash_wbuf mpw_flash_wbuf_chk #(.NUM_PANELS(NUM_PANELS)) chk_i (.*);

// File: tb/mpw_flash_wbuf_tb_top.sv
`timescale 1ns/100ps
module mpw_flash_wbuf_tb_top;
    localparam int NP = 4;
    localparam int DW = NP * 64;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0, wr_half = 1'b0;
    logic [21:0]   wr_ptr = '0;
    logic [15:0]   wr_data = '0;
    logic          cfg_we = 1'b0;
    logic [21:0]   cfg_addr = '0;
    logic [7:0]    cfg_data = '0;
    logic          commit_req = 1'b0;
    logic [21:3]   commit_ptr = '0;
    logic          prog_hold = 1'b0;
    logic          multi_mode, prog_strobe, cmt_err;
    logic [NP-1:0] prog_mask;
    logic [9:0]    prog_row;
    logic [DW-1:0] prog_data;
    logic [6:0]    erase_blk;

    logic [7:0] model [NP][8];
    int n_chk = 0, n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    mpw_flash_wbuf #(.NUM_PANELS(NP)) dut_i (.*);

    task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] model_vec();
        logic [DW-1:0] v;
        for (int p = 0; p < NP; p++)
            for (int b = 0; b < 8; b++) v[(p*8+b)*8 +: 8] = model[p][b];
        return v;
    endfunction

    task automatic model_erase();
        for (int p = 0; p < NP; p++)
            for (int b = 0; b < 8; b++) model[p][b] = 8'hFF;
    endtask

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic do_write(input logic [8:0] pnl, input logic [9:0] row, input logic [2:0] idx,
                            input logic half, input logic [15:0] d);
        wr_en = 1'b1; wr_half = half; wr_ptr = {pnl, row, idx}; wr_data = d;
        tick();
        wr_en = 1'b0;
    endtask

    task automatic do_cfg(input logic [21:0] a, input logic [7:0] d);
        cfg_we = 1'b1; cfg_addr = a; cfg_data = d;
        tick();
        cfg_we = 1'b0;
    endtask

    // Issue a commit and hold for hold_cyc cycles; checks strobe, mask, row, data, clear.
    task automatic do_commit(input logic [8:0] pnl, input logic [9:0] row, input int hold_cyc,
                             input logic [NP-1:0] exp_mask, input string req);
        prog_hold = 1'b1;
        commit_req = 1'b1; commit_ptr = {pnl, row};
        tick();
        commit_req = 1'b0;
        check({"R8 strobe up ", req}, DW'(prog_strobe), DW'(1));
        check({"R9 err clear ", req}, DW'(cmt_err), DW'(0));
        check({"mask ", req}, DW'(prog_mask), DW'(exp_mask));
        check({"R6 row ", req}, DW'(prog_row), DW'(row));
        check({"data ", req}, prog_data, model_vec());
        // R4: a write during the strobe is ignored.
        wr_en = 1'b1; wr_half = 1'b1; wr_ptr = {pnl, row, 3'd0}; wr_data = 16'h1234;
        tick();
        wr_en = 1'b0;
        check("R4 write during strobe", prog_data, model_vec());
        for (int c = 1; c < hold_cyc; c++) begin
            tick();
            check("R8 strobe held", DW'(prog_strobe), DW'(1));
        end
        prog_hold = 1'b0;
        tick();
        check("R8 strobe down", DW'(prog_strobe), DW'(0));
        model_erase();
        check("R10 cleared", prog_data, model_vec());
    endtask

    initial begin
        #200000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        model_erase();
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        // R1 reset state
        check("R1 strobe", DW'(prog_strobe), DW'(0));
        check("R1 err", DW'(cmt_err), DW'(0));
        check("R1 mode", DW'(multi_mode), DW'(0));
        check("R1 data", prog_data, model_vec());

        // R11 erase-region decode sweep
        for (int k = 0; k < 128; k++) begin
            wr_ptr = {9'd3, 7'(k), 6'(k * 5)};
            #1;
            check("R11 erase_blk", DW'(erase_blk), DW'(k));
        end

        // R2 / R4 byte sweep, including non-existent panels 4 and 5
        for (int p = 0; p < NP + 2; p++)
            for (int b = 0; b < 8; b++) begin
                logic [7:0] d;
                d = 8'(p * 37 + b * 11 + 5);
                do_write(9'(p), 10'h015, 3'(b), 1'b0, {8'hEE, d});
                if (p < NP) model[p][b] = d;
                check(p < NP ? "R2 byte write" : "R4 bad panel", prog_data, model_vec());
            end

        // R5 mode register
        do_cfg(22'h3C0006, 8'h40);
        check("R5 set", DW'(multi_mode), DW'(1));
        // R6 multi-panel commit
        do_commit(9'd1, 10'h015, 3, {NP{1'b1}}, "R6 multi");

        // R3 halfword sweep on panel 2, all byte positions
        for (int b = 0; b < 8; b++) begin
            logic [15:0] d;
            d = 16'(b * 16'h1111 + 16'h0A05);
            do_write(9'd2, 10'h020, 3'(b), 1'b1, d);
            model[2][b & 6] = d[7:0];
            model[2][b | 1] = d[15:8];
            check("R3 halfword", prog_data, model_vec());
        end

        // R5 other value clears, other address is ignored
        do_cfg(22'h3C0006, 8'h41);
        check("R5 clear", DW'(multi_mode), DW'(0));
        do_cfg(22'h3C0007, 8'h40);
        check("R5 other addr", DW'(multi_mode), DW'(0));

        // R7 single-panel commit
        do_commit(9'd2, 10'h020, 2, 4'b0100, "R7 single");

        // R9 mismatch
        do_write(9'd1, 10'h030, 3'd4, 1'b0, 16'h00C3);
        model[1][4] = 8'hC3;
        prog_hold = 1'b1;
        commit_req = 1'b1; commit_ptr = {9'd1, 10'h031};
        tick();
        commit_req = 1'b0;
        check("R9 refused strobe", DW'(prog_strobe), DW'(0));
        check("R9 err set", DW'(cmt_err), DW'(1));
        check("R9 buffers kept", prog_data, model_vec());
        do_commit(9'd1, 10'h030, 1, 4'b0010, "R9 retry");

        // R10 fresh state accepts any offset; single mode panel 3
        do_commit(9'd3, 10'h155, 1, 4'b1000, "R10 empty");
        // R5 config write during strobe is ignored
        prog_hold = 1'b1;
        commit_req = 1'b1; commit_ptr = {9'd0, 10'h155};
        tick();
        commit_req = 1'b0;
        do_cfg(22'h3C0006, 8'h40);
        check("R5 cfg during strobe", DW'(multi_mode), DW'(0));
        prog_hold = 1'b0;
        tick();
        check("R8 strobe down", DW'(prog_strobe), DW'(0));

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule